// File: doc/BRIEF.md
# Real-Mode Address Generator with Line-20 Gate

This block builds a physical memory address the way a legacy 16-bit processor does in real mode. The segment value is shifted four bits to the left and added to a 16-bit offset, which gives a 21-bit sum. Two load-strobed registers hold the operands: the code segment and the instruction pointer. On reset they take the fixed startup vector, so the first fetch address comes out as 0xFFFF0 with no software involved.

A gate controls address bit 20. When the gate is closed, bit 20 is forced low, so any sum at or above 1 MB wraps to the bottom of memory, which older code depends on. When the gate is open, the full 21-bit sum reaches the output. A separate carry flag reports bit 20 of the unmasked sum whatever the gate state, so a surrounding core can see when a wrap has occurred. The address is combinational from the registered operands and the registered gate state.

Top module: `rm_addr_gen`

## Requirements
- R1: The low 20 bits of `addr_o` equal the low 20 bits of (segment register × 16) + offset register.
- R2: While the gate register is 0, `addr_o[20]` is 0. Segment 0xF800 with offset 0x8000 gives 0x00000.
- R3: While the gate register is 1, `addr_o[20]` equals bit 20 of the full sum. Segment 0xF800 with offset 0x8000 gives 0x100000.
- R4: `carry_o` equals bit 20 of the unmasked 21-bit sum in both gate states.
- R5: Asynchronous reset (`rst_ni` low) loads the segment register with 0xF000 and the offset register with 0xFFF0. `addr_o` then reads 0xFFFF0 and `carry_o` reads 0.
- R6: The gate register clears to 0 on reset. It samples `gate_en_i` on every rising clock edge, and a change on `gate_en_i` affects `addr_o` only after that edge.
- R7: A high `seg_ld_i` (or `off_ld_i`) at a rising edge loads `seg_i` (or `off_i`) into its register. Each register loads independently, and `addr_o` reflects the new value straight after that edge.
- R8: With its strobe low, a register holds its value, and changes on `seg_i`/`off_i` have no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_ld_i | input | 1 | Segment register load strobe |
| seg_i | input | 16 | Segment value to load |
| off_ld_i | input | 1 | Offset register load strobe |
| off_i | input | 16 | Offset value to load |
| gate_en_i | input | 1 | Address line 20 gate enable, registered each cycle |
| addr_o | output | 21 | Physical address after gating |
| carry_o | output | 1 | Unmasked sum reached 1 MB or more |

## Verification
The bench builds the block with its default parameters: 16-bit segment and offset and a 4-bit shift, which gives a 21-bit address. With these values, every sum that can cross 1 MB can be reached. The sweep covers segments from 0xEFF0 to 0xFFFF against a grid of offsets. For each segment it adds the offsets that land exactly one below and exactly on the 1 MB boundary, and it runs every pair in both gate states. Directed cases cover the startup vector, a reset applied in mid-run, loading one register on its own, inputs ignored while the strobes are low, and the one-edge delay on the gate.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  localparam int unsigned SEG_W = 16;
  localparam int unsigned OFF_W = 16;
  localparam int unsigned SHIFT = 4;
  localparam logic [15:0] CS_RST = 16'hF000;
  localparam logic [15:0] IP_RST = 16'hFFF0;
endpackage

// File: rtl/rm_ld_reg.sv
module rm_ld_reg #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (ld_i) q_o <= d_i;
  end

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/rm_addr_sum.sv
module rm_addr_sum #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = SEG_W + SHIFT + 1
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] sum_o
);
  logic [ADDR_W-1:0] seg_ext, off_ext;

  assign seg_ext = ADDR_W'({seg_i, {SHIFT{1'b0}}});
  assign off_ext = ADDR_W'(off_i);
  assign sum_o   = seg_ext + off_ext;
endmodule

// File: rtl/rm_line_gate.sv
module rm_line_gate #(
  parameter int unsigned ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] sum_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              carry_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b == TOP) begin : g_gated
      assign addr_o[b] = sum_i[b] & en_i;
    end else begin : g_pass
      assign addr_o[b] = sum_i[b];
    end
  end

  assign carry_o = sum_i[TOP];
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen import rm_addr_pkg::*; #(
  parameter int unsigned SEG_W = rm_addr_pkg::SEG_W,
  parameter int unsigned OFF_W = rm_addr_pkg::OFF_W,
  parameter int unsigned SHIFT = rm_addr_pkg::SHIFT,
  parameter logic [SEG_W-1:0] CS_INIT = rm_addr_pkg::CS_RST,
  parameter logic [OFF_W-1:0] IP_INIT = rm_addr_pkg::IP_RST,
  localparam int unsigned ADDR_W = SEG_W + SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_ld_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              off_ld_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              gate_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              carry_o
);
  localparam int unsigned LW = ADDR_W - 1;

  logic [SEG_W-1:0]  cs_q;
  logic [OFF_W-1:0]  ip_q;
  logic [ADDR_W-1:0] sum;
  logic              gate_q;

  rm_ld_reg #(.W(SEG_W), .RST(CS_INIT)) u_cs (
    .clk_i, .rst_ni, .ld_i(seg_ld_i), .d_i(seg_i), .q_o(cs_q)
  );

  rm_ld_reg #(.W(OFF_W), .RST(IP_INIT)) u_ip (
    .clk_i, .rst_ni, .ld_i(off_ld_i), .d_i(off_i), .q_o(ip_q)
  );

  rm_addr_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_sum (
    .seg_i(cs_q), .off_i(ip_q), .sum_o(sum)
  );

  // gate starts closed: wrap-around mode after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_en_i;
  end

  rm_line_gate #(.ADDR_W(ADDR_W)) u_gate (
    .sum_i(sum), .en_i(gate_q), .addr_o, .carry_o
  );

  assert_low_bits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[LW-1:0] - LW'(ip_q)) == LW'({cs_q, {SHIFT{1'b0}}}));
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_q |-> !addr_o[LW]);
  assert_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> addr_o[LW] == carry_o);
  assert_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_o |-> (LW'({cs_q, {SHIFT{1'b0}}}) <= addr_o[LW-1:0]));
  assert_gate_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> gate_q == $past(gate_en_i));
endmodule

// File: tb/rm_addr_gen_tb.sv
module rm_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_ld = 1'b0, off_ld = 1'b0, gate_en = 1'b0;
  logic [15:0] seg = '0, off = '0;
  logic [20:0] addr;
  logic        carry;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rm_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .seg_ld_i(seg_ld), .seg_i(seg),
    .off_ld_i(off_ld), .off_i(off), .gate_en_i(gate_en),
    .addr_o(addr), .carry_o(carry)
  );

  task automatic chk(string tag, logic [20:0] got, logic [20:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [20:0] full_sum(logic [15:0] s, logic [15:0] o);
    return {5'b0, s, 4'b0} + {5'b0, o};
  endfunction

  task automatic apply(logic [15:0] s, logic [15:0] o, logic g);
    logic [20:0] fs, ex;
    @(negedge clk);
    seg = s; off = o; gate_en = g; seg_ld = 1'b1; off_ld = 1'b1;
    @(negedge clk);
    seg_ld = 1'b0; off_ld = 1'b0;
    fs = full_sum(s, o);
    ex = g ? fs : {1'b0, fs[19:0]};
    if (!fs[20])  chk("R1 addr", addr, ex);
    else if (!g)  chk("R2 wrap", addr, ex);
    else          chk("R3 pass", addr, ex);
    chk("R4 carry", {20'b0, carry}, {20'b0, fs[20]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    chk("R5 reset addr", addr, 21'h0FFFF0);
    chk("R5 reset carry", {20'b0, carry}, 21'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset vector held", addr, 21'h0FFFF0);

    apply(16'hF800, 16'h8000, 1'b0);
    apply(16'hF800, 16'h8000, 1'b1);

    // R6: gate input change acts only after the edge
    apply(16'hF800, 16'h8000, 1'b0);
    gate_en = 1'b1; #1;
    chk("R6 gate before edge", addr, 21'h000000);
    @(negedge clk);
    chk("R6 gate after edge", addr, 21'h100000);

    // R8: inputs ignored without strobes
    seg = 16'h1234; off = 16'h0042;
    repeat (3) @(negedge clk);
    chk("R8 hold", addr, 21'h100000);

    // R7: segment only, then offset only
    seg_ld = 1'b1; seg = 16'h1000;
    @(negedge clk); seg_ld = 1'b0;
    chk("R7 seg only", addr, 21'h018000);
    off_ld = 1'b1; off = 16'h0005;
    @(negedge clk); off_ld = 1'b0;
    chk("R7 off only", addr, 21'h010005);

    // R5: asynchronous reset mid-run
    #1 rst_n = 1'b0; #1;
    chk("R5 async reset", addr, 21'h0FFFF0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R5 after reset", addr, 21'h0FFFF0);

    // near-exhaustive sweep around 1 MB
    for (int s = 16'hEFF0; s <= 16'hFFFF; s += 15) begin
      logic [20:0] edge_off;
      edge_off = 21'h100000 - {5'b0, s[15:0], 4'b0};
      for (int g = 0; g < 2; g++) begin
        for (int i = 0; i < 16; i++)
          apply(s[15:0], 16'(i * 16'h1111), g[0]);
        if (edge_off <= 21'h00FFFF) begin
          apply(s[15:0], edge_off[15:0], g[0]);
          if (edge_off != 0) apply(s[15:0], 16'(edge_off - 1), g[0]);
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule